// File: doc/BRIEF.md
# MIDI Note Message Decoder

This block listens to a raw serial MIDI line and reports note events. It brings the asynchronous input into the clock domain and recovers bit timing from a free-running count of system clocks per bit. It assembles 8N1 bytes, sent least significant bit first, and passes them to a small parser.

The parser acts on three channel-message kinds: note-on, note-off and polyphonic key pressure. All other traffic is skipped. For each complete message the block raises a one-cycle strobe together with the message kind, the channel, the note number and the velocity or pressure.

Top module: `midi_note_decoder`

## Requirements
- R1: While reset is asserted and after it is released, before any message completes, `msg_valid_o` is low and `msg_type_o`, `channel_o`, `note_o` and `value_o` are zero.
- R2: A byte is a low start bit, eight data bits sent LSB first, and a high stop bit. Each bit lasts `CLKS_PER_BIT` clocks and is sampled near its middle. Byte values are recovered exactly.
- R3: A byte whose stop bit samples low is discarded, as if it had never been sent.
- R4: Status `0x9n` followed by data bytes `k` and `v` (with `v` non-zero) reports `msg_type_o`=1 (note-on), `channel_o`=n, `note_o`=k and `value_o`=v.
- R5: Status `0x8n` followed by `k` and `v` reports `msg_type_o`=0 (note-off), with channel n, note k and value v.
- R6: Status `0xAn` followed by `k` and `p` reports `msg_type_o`=2 (key pressure), with channel n, note k and value p.
- R7: A note-on whose velocity byte is 0 is reported with `msg_type_o`=0.
- R8: A status byte (MSB set) whose upper nibble is not 8, 9 or A is ignored, and so are the data bytes after it. Any status byte that arrives in the middle of a message abandons the partial message.
- R9: Once a message completes, each further pair of data bytes (MSB clear) reuses the last accepted status byte and produces another message.
- R10: `msg_valid_o` is high for exactly one cycle per message.
- R11: A low pulse on the line that has ended by the middle of the start bit does not start a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| midi_rx_i | input | 1 | Asynchronous serial MIDI line, idle high |
| msg_valid_o | output | 1 | One-cycle strobe for a decoded message |
| msg_type_o | output | 2 | 0 note-off, 1 note-on, 2 key pressure |
| channel_o | output | 4 | Channel from the low nibble of the status byte |
| note_o | output | 7 | Note number |
| value_o | output | 7 | Velocity or pressure |

## Verification
Byte values with uneven bit patterns, such as 0x55, 0x2A and channel 15, show whether the bit order and the centre sampling are correct.

The three accepted status kinds are each sent once. A zero-velocity note-on is sent to confirm it is remapped. A run of extra data pairs tests status reuse.

Controller, program-change and real-time bytes, some of them placed inside a message, show whether unrelated traffic is dropped and a partial message is abandoned. Frames with a low stop bit, on a status byte and on a data byte, together with a short low glitch, show that bad frames are rejected and that the receiver then recovers.

// File: rtl/midi_pkg.sv
package midi_pkg;
  typedef enum logic [1:0] {
    MSG_NOTE_OFF = 2'd0,
    MSG_NOTE_ON  = 2'd1,
    MSG_KEY_PRES = 2'd2
  } msg_kind_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PS_IDLE, PS_DATA1, PS_DATA2
  } parse_state_e;
endpackage

// File: rtl/midi_sync.sv
module midi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // idle-high line
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/midi_uart_rx.sv
module midi_uart_rx
  import midi_pkg::*;
#(
  parameter int CLKS_PER_BIT = 800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_idx_q;
  logic [7:0]    shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      bit_idx_q    <= '0;
      shreg_q      <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_i) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == HALF_M1) begin
            cnt_q     <= '0;
            bit_idx_q <= '0;
            state_q   <= rx_i ? RX_IDLE : RX_DATA;  // glitch rejection
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == FULL_M1) begin
            cnt_q   <= '0;
            shreg_q <= {rx_i, shreg_q[7:1]};  // LSB arrives first
            if (bit_idx_q == 3'd7) state_q <= RX_STOP;
            else bit_idx_q <= bit_idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == FULL_M1) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (rx_i) begin
              byte_o       <= shreg_q;
              byte_valid_o <= 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  p_byte_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  p_byte_after_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(state_q == RX_STOP) && state_q == RX_IDLE);

  p_start_needs_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && cnt_q == HALF_M1 && rx_i) |=> state_q == RX_IDLE);
endmodule

// File: rtl/midi_msg_parser.sv
module midi_msg_parser
  import midi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  output logic       msg_valid_o,
  output logic [1:0] msg_type_o,
  output logic [3:0] channel_o,
  output logic [6:0] note_o,
  output logic [6:0] value_o
);
  parse_state_e state_q;
  msg_kind_e    kind_q;
  logic [3:0]   chan_q;
  logic [6:0]   note_q;
  logic         wanted;

  assign wanted = byte_i[6:4] <= 3'b010;  // 0x8n, 0x9n, 0xAn

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_IDLE;
      kind_q      <= MSG_NOTE_OFF;
      chan_q      <= '0;
      note_q      <= '0;
      msg_valid_o <= 1'b0;
      msg_type_o  <= '0;
      channel_o   <= '0;
      note_o      <= '0;
      value_o     <= '0;
    end else begin
      msg_valid_o <= 1'b0;
      if (byte_valid_i) begin
        if (byte_i[7]) begin
          if (wanted) begin
            kind_q  <= msg_kind_e'(byte_i[5:4]);
            chan_q  <= byte_i[3:0];
            state_q <= PS_DATA1;
          end else state_q <= PS_IDLE;
        end else begin
          unique case (state_q)
            PS_DATA1: begin
              note_q  <= byte_i[6:0];
              state_q <= PS_DATA2;
            end
            PS_DATA2: begin
              msg_valid_o <= 1'b1;
              msg_type_o  <= (kind_q == MSG_NOTE_ON && byte_i[6:0] == '0)
                             ? MSG_NOTE_OFF : kind_q;
              channel_o   <= chan_q;
              note_o      <= note_q;
              value_o     <= byte_i[6:0];
              state_q     <= PS_DATA1;  // running status
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o);

  p_type_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_type_o != 2'd3);

  p_on_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_NOTE_ON) |-> value_o != '0);

  p_valid_after_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> $past(byte_valid_i && !byte_i[7]));
endmodule

// File: rtl/midi_note_decoder.sv
module midi_note_decoder #(
  parameter int CLKS_PER_BIT = 800,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       midi_rx_i,
  output logic       msg_valid_o,
  output logic [1:0] msg_type_o,
  output logic [3:0] channel_o,
  output logic [6:0] note_o,
  output logic [6:0] value_o
);
  logic       rx_sync;
  logic [7:0] rx_byte;
  logic       rx_byte_valid;

  midi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (midi_rx_i),
    .q_o   (rx_sync)
  );

  midi_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_i        (rx_sync),
    .byte_o      (rx_byte),
    .byte_valid_o(rx_byte_valid)
  );

  midi_msg_parser u_parse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (rx_byte),
    .byte_valid_i(rx_byte_valid),
    .msg_valid_o (msg_valid_o),
    .msg_type_o  (msg_type_o),
    .channel_o   (channel_o),
    .note_o      (note_o),
    .value_o     (value_o)
  );
endmodule

// File: tb/sim_midi_note_decoder.sv
module sim_midi_note_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int CLKS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       msg_valid;
  logic [1:0] msg_type;
  logic [3:0] channel;
  logic [6:0] note, value;

  int n_checks = 0;
  int n_fail = 0;
  bit monitor_on = 1'b0;
  bit prev_valid = 1'b0;
  string cur_req = "R1";

  logic [19:0] exp_q[$];
  string       req_q[$];

  // behavioural parser model
  int       m_state = 0;
  bit [1:0] m_kind;
  bit [3:0] m_chan;
  bit [6:0] m_note;

  always #(CLK_PERIOD / 2) clk = ~clk;

  midi_note_decoder #(.CLKS_PER_BIT(CLKS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .midi_rx_i(rx),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .channel_o(channel),
    .note_o(note), .value_o(value)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (b[7]) begin
      if (b[6:4] <= 3'd2) begin
        m_kind = b[5:4]; m_chan = b[3:0]; m_state = 1;
      end else m_state = 0;
    end else if (m_state == 1) begin
      m_note = b[6:0]; m_state = 2;
    end else if (m_state == 2) begin
      exp_q.push_back({(m_kind == 2'd1 && b[6:0] == 0) ? 2'd0 : m_kind,
                       m_chan, m_note, b[6:0]});
      req_q.push_back(cur_req);
      m_state = 1;
    end
  endtask

  task automatic drive_frame(input logic [7:0] b, input bit good_stop);
    rx = 1'b0;
    repeat (CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CLKS) @(negedge clk);
    end
    rx = good_stop;
    repeat (CLKS) @(negedge clk);
    rx = 1'b1;
    repeat (2 * CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    model_byte(b);
    drive_frame(b, 1'b1);
  endtask

  task automatic drained(input string req);
    check(req, exp_q.size() == 0, "messages still pending", exp_q.size(), 0);
    exp_q.delete(); req_q.delete();
  endtask

  // compare on every clock
  always @(negedge clk) begin
    if (monitor_on) begin
      check("R10", !(prev_valid && msg_valid), "valid longer than one cycle", 1, 0);
      if (msg_valid) begin
        if (exp_q.size() == 0) begin
          check(cur_req, 1'b0, "unexpected message",
                {msg_type, channel, note, value}, 0);
        end else begin
          automatic logic [19:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          check(r, {msg_type, channel, note, value} == e, "message",
                {msg_type, channel, note, value}, e);
        end
      end
      prev_valid = msg_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1'b0, "timeout", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", !msg_valid && msg_type == 0 && channel == 0 && note == 0 && value == 0,
          "outputs in reset", {msg_valid, msg_type, channel, note, value}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", !msg_valid && msg_type == 0 && note == 0 && value == 0,
          "outputs after reset", {msg_valid, msg_type, channel, note, value}, 0);
    monitor_on = 1'b1;

    cur_req = "R4"; send(8'h93); send(8'h3C); send(8'h64); drained("R4");
    cur_req = "R5"; send(8'h85); send(8'h3C); send(8'h40); drained("R5");
    cur_req = "R6"; send(8'hA0); send(8'h10); send(8'h7F); drained("R6");
    cur_req = "R7"; send(8'h92); send(8'h40); send(8'h00); drained("R7");
    cur_req = "R2"; send(8'h9F); send(8'h55); send(8'h2A); drained("R2");
    cur_req = "R9";
    send(8'h91); send(8'h30); send(8'h50); send(8'h32); send(8'h51);
    send(8'h34); send(8'h00); drained("R9");

    cur_req = "R8";
    send(8'hB0); send(8'h07); send(8'h7F);
    send(8'hC4); send(8'h05);
    send(8'h90); send(8'h20); send(8'hF8); send(8'h30); send(8'h31);
    drained("R8");
    send(8'h90); send(8'h20); send(8'h90); send(8'h22); send(8'h33);
    drained("R8");

    cur_req = "R3";
    drive_frame(8'h94, 1'b0); send(8'h11); send(8'h22);
    drained("R3");
    send(8'h94); drive_frame(8'h11, 1'b0); send(8'h22); send(8'h33);
    drained("R3");

    cur_req = "R11";
    rx = 1'b0; repeat (3) @(negedge clk); rx = 1'b1;
    repeat (2 * CLKS) @(negedge clk);
    drained("R11");
    send(8'h80); send(8'h01); send(8'h02);
    drained("R11");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule